// File: doc/BRIEF.md
# Pipelined Floating-Point Adder-Subtractor

This block adds or subtracts two floating-point numbers in a four-segment pipeline that accepts one operation per clock. An operand is a sign bit, an unsigned exponent field and a fraction field. The value is (-1)^sign * 0.frac * 2^exp. A normalized fraction has its most significant bit set. A fraction of all zeros stands for zero. A control bit selects addition or subtraction, and a valid flag goes with each operation.

The segments run in a fixed order: exponent comparison, alignment of the smaller operand's fraction, sign-magnitude add or subtract of the fractions, and normalization. Each segment ends in a register, so up to four independent operations are in flight at once. Bits shifted out during alignment or normalization are dropped: the arithmetic truncates and does not round. The exponent and fraction widths are parameters. The block has no special encodings: no infinities, no NaNs, no denormals. All exponent arithmetic wraps modulo 2^EXP_W.

Top module: `fpa_pipe`

## Requirements
- R1: With `in_op`=0 the result is A+B. With `in_op`=1 the result is A−B, formed by inverting B's sign before any other step.
- R2: The result exponent before normalization is the larger of the two exponents. When the exponents are equal, A is treated as the larger-exponent operand.
- R3: The fraction of the smaller-exponent operand is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of FRAC_W or more turns that fraction into zero.
- R4: When the effective signs agree, the aligned fractions are added and the result takes their common sign.
- R5: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger one and the result takes the sign of the larger. If the larger-exponent fraction is the smaller magnitude, the other operand's sign is used.
- R6: If the fraction sum carries out, the fraction is shifted right one place (its lowest bit is dropped) and the exponent is incremented by one, modulo 2^EXP_W.
- R7: A nonzero result without carry is shifted left by its count of leading zeros, and the exponent is reduced by that count, modulo 2^EXP_W. Every nonzero output fraction has bit FRAC_W-1 set.
- R8: A result whose magnitude is exactly zero is output as sign 0, exponent 0 and fraction 0.
- R9: `out_valid` equals `in_valid` from four clocks earlier. Operations can enter back to back, one per clock, with gaps of any length, and results leave in the order they entered.
- R10: While `rst_n` is low and until the first operation has passed through, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the valid flags |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of operand A (1 = negative) |
| a_exp | input | EXP_W | Exponent of operand A |
| a_frac | input | FRAC_W | Fraction of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| b_frac | input | FRAC_W | Fraction of operand B |
| out_valid | output | 1 | A result is present this cycle |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_frac | output | FRAC_W | Result fraction, normalized or zero |

## Verification
The hardest case to reach is deep cancellation: two nearly equal magnitudes with opposite effective signs. Only this case produces long leading-zero runs and exponent underflow that wraps past zero. Random operands with independent exponents almost never land there. The stimulus therefore includes a mode that gives both operands the same exponent, makes B's fraction differ from A's only in its low bits, and picks the operator so that the effective signs are opposite. Directed cases add exact cancellation, a one-bit residue, carry-out on equal operands, and alignment distances at and beyond the fraction width.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
package fpa_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpa_op_e;
endpackage

// File: rtl/fpa_exp_cmp.sv
`timescale 1ns/1ps
module fpa_exp_cmp #(
  parameter int EW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_op,
  input  logic          a_sign,
  input  logic [EW-1:0] a_exp,
  input  logic [FW-1:0] a_frac,
  input  logic          b_sign,
  input  logic [EW-1:0] b_exp,
  input  logic [FW-1:0] b_frac,
  output logic          s1_valid,
  output logic [EW-1:0] s1_exp,
  output logic [EW-1:0] s1_shamt,
  output logic          s1_sign_big,
  output logic [FW-1:0] s1_frac_big,
  output logic          s1_sign_sml,
  output logic [FW-1:0] s1_frac_sml
);
  import fpa_pkg::*;

  function automatic logic [EW-1:0] exp_gap(input logic [EW-1:0] hi, input logic [EW-1:0] lo);
    return hi - lo;
  endfunction

  logic          b_eff_sign;
  logic          swap_evt;
  logic [EW-1:0] exp_hi, gap;
  logic          sign_hi, sign_lo;
  logic [FW-1:0] frac_hi, frac_lo;

  assign b_eff_sign = b_sign ^ (fpa_op_e'(in_op) == OP_SUB);
  assign swap_evt   = (b_exp > a_exp);

  always_comb begin
    if (swap_evt) begin
      exp_hi  = b_exp;
      gap     = exp_gap(b_exp, a_exp);
      sign_hi = b_eff_sign;
      frac_hi = b_frac;
      sign_lo = a_sign;
      frac_lo = a_frac;
    end else begin
      exp_hi  = a_exp;
      gap     = exp_gap(a_exp, b_exp);
      sign_hi = a_sign;
      frac_hi = a_frac;
      sign_lo = b_eff_sign;
      frac_lo = b_frac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    s1_exp      <= exp_hi;
    s1_shamt    <= gap;
    s1_sign_big <= sign_hi;
    s1_frac_big <= frac_hi;
    s1_sign_sml <= sign_lo;
    s1_frac_sml <= frac_lo;
  end

  // R2
  exp_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_exp >= $past(a_exp)) && (s1_exp >= $past(b_exp)));

  // R2
  exp_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_exp == b_exp)) |=> (s1_shamt == '0) && (s1_frac_big == $past(a_frac)));
endmodule

// File: rtl/fpa_align.sv
`timescale 1ns/1ps
module fpa_align #(
  parameter int EW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s1_valid,
  input  logic [EW-1:0] s1_exp,
  input  logic [EW-1:0] s1_shamt,
  input  logic          s1_sign_big,
  input  logic [FW-1:0] s1_frac_big,
  input  logic          s1_sign_sml,
  input  logic [FW-1:0] s1_frac_sml,
  output logic          s2_valid,
  output logic [EW-1:0] s2_exp,
  output logic          s2_sign_big,
  output logic [FW-1:0] s2_frac_big,
  output logic          s2_sign_sml,
  output logic [FW-1:0] s2_frac_sml
);
  function automatic logic [FW-1:0] shift_down(input logic [FW-1:0] f, input logic [EW-1:0] sh);
    if (32'(sh) >= FW) return '0;
    return f >> sh;
  endfunction

  logic          flush_evt;
  logic [FW-1:0] frac_aligned;

  assign flush_evt    = (32'(s1_shamt) >= FW);
  assign frac_aligned = shift_down(s1_frac_sml, s1_shamt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    s2_exp      <= s1_exp;
    s2_sign_big <= s1_sign_big;
    s2_frac_big <= s1_frac_big;
    s2_sign_sml <= s1_sign_sml;
    s2_frac_sml <= frac_aligned;
  end

  // R3
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && flush_evt) |=> (s2_frac_sml == '0));

  // R3
  align_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (s2_frac_sml <= $past(s1_frac_sml)));
endmodule

// File: rtl/fpa_mant_addsub.sv
`timescale 1ns/1ps
module fpa_mant_addsub #(
  parameter int EW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s2_valid,
  input  logic [EW-1:0] s2_exp,
  input  logic          s2_sign_big,
  input  logic [FW-1:0] s2_frac_big,
  input  logic          s2_sign_sml,
  input  logic [FW-1:0] s2_frac_sml,
  output logic          s3_valid,
  output logic [EW-1:0] s3_exp,
  output logic          s3_sign,
  output logic [FW:0]   s3_mag
);
  function automatic logic [FW:0] mag_sum(input logic [FW-1:0] x, input logic [FW-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [FW:0] mag_diff(input logic [FW-1:0] x, input logic [FW-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  logic        same_sign_evt;
  logic        sml_wins_evt;
  logic [FW:0] mag_nxt;
  logic        sign_nxt;

  assign same_sign_evt = (s2_sign_big == s2_sign_sml);
  assign sml_wins_evt  = !same_sign_evt && (s2_frac_sml > s2_frac_big);

  always_comb begin
    if (same_sign_evt) begin
      mag_nxt  = mag_sum(s2_frac_big, s2_frac_sml);
      sign_nxt = s2_sign_big;
    end else if (sml_wins_evt) begin
      mag_nxt  = mag_diff(s2_frac_sml, s2_frac_big);
      sign_nxt = s2_sign_sml;
    end else begin
      mag_nxt  = mag_diff(s2_frac_big, s2_frac_sml);
      sign_nxt = s2_sign_big;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s3_valid <= 1'b0;
    else        s3_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    s3_exp  <= s2_exp;
    s3_sign <= sign_nxt;
    s3_mag  <= mag_nxt;
  end

  // R5
  diff_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !same_sign_evt) |=> !s3_mag[FW]);

  // R4
  sum_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && same_sign_evt) |=> (s3_sign == $past(s2_sign_big)));
endmodule

// File: rtl/fpa_normalize.sv
`timescale 1ns/1ps
module fpa_normalize #(
  parameter int EW = 8,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s3_valid,
  input  logic [EW-1:0] s3_exp,
  input  logic          s3_sign,
  input  logic [FW:0]   s3_mag,
  output logic          out_valid,
  output logic          out_sign,
  output logic [EW-1:0] out_exp,
  output logic [FW-1:0] out_frac
);
  localparam int LZW = $clog2(FW + 1);

  function automatic logic [LZW-1:0] lead_zeros(input logic [FW-1:0] m);
    logic [LZW-1:0] n;
    logic           hit;
    n   = LZW'(FW);
    hit = 1'b0;
    for (int i = FW - 1; i >= 0; i--) begin
      if (!hit && m[i]) begin
        n   = LZW'(FW - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic           zero_evt, ovf_evt, lz_evt;
  logic [LZW-1:0] lz;
  logic           sign_nxt;
  logic [EW-1:0]  exp_nxt;
  logic [FW-1:0]  frac_nxt;

  assign zero_evt = (s3_mag == '0);
  assign ovf_evt  = s3_mag[FW];
  assign lz       = lead_zeros(s3_mag[FW-1:0]);
  assign lz_evt   = !zero_evt && !ovf_evt && (lz != '0);

  always_comb begin
    if (zero_evt) begin
      sign_nxt = 1'b0;
      exp_nxt  = '0;
      frac_nxt = '0;
    end else if (ovf_evt) begin
      sign_nxt = s3_sign;
      exp_nxt  = s3_exp + EW'(1);
      frac_nxt = s3_mag[FW:1];
    end else begin
      sign_nxt = s3_sign;
      exp_nxt  = s3_exp - EW'(lz);
      frac_nxt = s3_mag[FW-1:0] << lz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s3_valid;
  end

  always_ff @(posedge clk) begin
    out_sign <= sign_nxt;
    out_exp  <= exp_nxt;
    out_frac <= frac_nxt;
  end

  // R8
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_frac == '0)) |-> ((out_exp == '0) && !out_sign));

  // R7
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_frac != '0)) |-> out_frac[FW-1]);

  // R6
  carry_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_valid && ovf_evt) |=> (out_exp == $past(s3_exp) + EW'(1)));

  // R7
  lz_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_valid && lz_evt) |=> (out_exp != $past(s3_exp)));
endmodule

// File: rtl/fpa_pipe.sv
`timescale 1ns/1ps
module fpa_pipe #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac
);
  localparam int DEPTH = 4;

  logic              s1_valid, s1_sign_big, s1_sign_sml;
  logic [EXP_W-1:0]  s1_exp, s1_shamt;
  logic [FRAC_W-1:0] s1_frac_big, s1_frac_sml;

  logic              s2_valid, s2_sign_big, s2_sign_sml;
  logic [EXP_W-1:0]  s2_exp;
  logic [FRAC_W-1:0] s2_frac_big, s2_frac_sml;

  logic              s3_valid, s3_sign;
  logic [EXP_W-1:0]  s3_exp;
  logic [FRAC_W:0]   s3_mag;

  fpa_exp_cmp #(.EW(EXP_W), .FW(FRAC_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .s1_valid(s1_valid), .s1_exp(s1_exp), .s1_shamt(s1_shamt),
    .s1_sign_big(s1_sign_big), .s1_frac_big(s1_frac_big),
    .s1_sign_sml(s1_sign_sml), .s1_frac_sml(s1_frac_sml)
  );

  fpa_align #(.EW(EXP_W), .FW(FRAC_W)) u_align (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_exp(s1_exp), .s1_shamt(s1_shamt),
    .s1_sign_big(s1_sign_big), .s1_frac_big(s1_frac_big),
    .s1_sign_sml(s1_sign_sml), .s1_frac_sml(s1_frac_sml),
    .s2_valid(s2_valid), .s2_exp(s2_exp),
    .s2_sign_big(s2_sign_big), .s2_frac_big(s2_frac_big),
    .s2_sign_sml(s2_sign_sml), .s2_frac_sml(s2_frac_sml)
  );

  fpa_mant_addsub #(.EW(EXP_W), .FW(FRAC_W)) u_addsub (
    .clk(clk), .rst_n(rst_n),
    .s2_valid(s2_valid), .s2_exp(s2_exp),
    .s2_sign_big(s2_sign_big), .s2_frac_big(s2_frac_big),
    .s2_sign_sml(s2_sign_sml), .s2_frac_sml(s2_frac_sml),
    .s3_valid(s3_valid), .s3_exp(s3_exp), .s3_sign(s3_sign), .s3_mag(s3_mag)
  );

  fpa_normalize #(.EW(EXP_W), .FW(FRAC_W)) u_norm (
    .clk(clk), .rst_n(rst_n),
    .s3_valid(s3_valid), .s3_exp(s3_exp), .s3_sign(s3_sign), .s3_mag(s3_mag),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_frac(out_frac)
  );

  // Edges seen since reset, saturating at the pipeline depth.
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '0;
    else if (age != 3'(DEPTH)) age <= age + 3'd1;
  end

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'(DEPTH)) |-> (out_valid == $past(in_valid, 4)));

  // R10
  startup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age < 3'(DEPTH)) |-> !out_valid);
endmodule

// File: tb/fpa_pipe_tb.sv
`timescale 1ns/1ps
module fpa_pipe_tb;
  localparam int EW = 8;
  localparam int FW = 16;

  typedef struct {
    bit            v;
    bit            s;
    bit [EW-1:0]   e;
    bit [FW-1:0]   f;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_op = 1'b0;
  logic          a_sign = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [FW-1:0] a_frac = '0, b_frac = '0;
  logic          out_valid, out_sign;
  logic [EW-1:0] out_exp;
  logic [FW-1:0] out_frac;

  int checks = 0;
  int errors = 0;
  exp_t pend[$];

  always #5 clk = ~clk;

  fpa_pipe #(.EXP_W(EW), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_frac(out_frac)
  );

  // Reference: signed integer sum of the truncated, aligned fractions.
  function automatic exp_t ref_op(bit v, bit op, bit as, int ae, longint af,
                                  bit bs, int be, longint bf);
    exp_t   r;
    bit     sb, ss, beff;
    int     eb, d;
    longint fb, fs, sum, m;
    r.v = v; r.s = 0; r.e = '0; r.f = '0; r.tag = "R9";
    if (!v) return r;
    beff = bs ^ op;                                  // R1
    if (ae >= be) begin eb = ae; d = ae - be; sb = as;   fb = af; ss = beff; fs = bf; end
    else          begin eb = be; d = be - ae; sb = beff; fb = bf; ss = as;   fs = af; end
    fs = (d >= FW) ? 0 : (fs >> d);                  // R3
    sum = (sb ? -fb : fb) + (ss ? -fs : fs);
    r.tag = (sb == ss) ? "R4" : "R5";
    if (d >= FW) r.tag = "R3";
    if (sum == 0) begin r.tag = "R8"; return r; end
    r.s = (sum < 0);
    m = r.s ? -sum : sum;
    if (m >= (64'd1 << FW)) begin
      m = m >> 1; eb = eb + 1; r.tag = "R6";
    end else begin
      while (m < (64'd1 << (FW - 1))) begin
        m = m << 1; eb = eb - 1; r.tag = "R7";
      end
    end
    r.e = EW'(eb & ((1 << EW) - 1));
    r.f = FW'(m);
    return r;
  endfunction

  task automatic check_out();
    exp_t x;
    if (pend.size() < 4) begin
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10 out_valid before first result: got %b expected 0", out_valid);
      end
      return;
    end
    x = pend.pop_front();
    checks++;
    if (out_valid !== x.v) begin
      errors++;
      $display("FAIL R9 out_valid: got %b expected %b", out_valid, x.v);
    end else if (x.v) begin
      checks++;
      if (out_sign !== x.s || out_exp !== x.e || out_frac !== x.f) begin
        errors++;
        $display("FAIL %s result: got s=%0b e=%0h f=%0h expected s=%0b e=%0h f=%0h",
                 x.tag, out_sign, out_exp, out_frac, x.s, x.e, x.f);
      end
    end
  endtask

  task automatic step(bit v, bit op, bit as, bit [EW-1:0] ae, bit [FW-1:0] af,
                      bit bs, bit [EW-1:0] be, bit [FW-1:0] bf);
    @(negedge clk);
    check_out();
    in_valid = v; in_op = op;
    a_sign = as; a_exp = ae; a_frac = af;
    b_sign = bs; b_exp = be; b_frac = bf;
    pend.push_back(ref_op(v, op, as, int'(ae), longint'(af), bs, int'(be), longint'(bf)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    // R10: outputs idle during reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R10 out_valid in reset: got %b expected 0", out_valid);
      end
    end
    rst_n = 1'b1;

    // Directed corner cases
    step(1, 0, 0, 8'd10, 16'h8000, 0, 8'd10, 16'h8000);   // R6 carry-out
    step(1, 1, 0, 8'd10, 16'hA5A5, 0, 8'd10, 16'hA5A5);   // R8 exact cancel
    step(1, 1, 0, 8'd5,  16'h8001, 0, 8'd5,  16'h8000);   // R7 wraps below zero
    step(1, 0, 0, 8'd40, 16'hC000, 0, 8'd24, 16'hFFFF);   // R3 diff = FW
    step(1, 0, 1, 8'd200,16'h9000, 0, 8'd150,16'hFFFF);   // R3 diff > FW
    step(1, 1, 0, 8'd3,  16'h8000, 0, 8'd7,  16'hF000);   // R1/R2 swap, negative
    step(1, 1, 0, 8'd9,  16'h9000, 1, 8'd9,  16'h9000);   // R1 sub of negative = add
    step(1, 0, 0, 8'd255,16'hFFFF, 0, 8'd255,16'hFFFF);   // R6 exponent wraps
    step(1, 0, 0, 8'd20, 16'h8000, 1, 8'd20, 16'hC000);   // R5 smaller-exponent side wins
    step(0, 0, 0, 8'd0,  16'h0,    0, 8'd0,  16'h0);      // R9 bubble
    step(1, 0, 1, 8'd12, 16'h8000, 1, 8'd11, 16'h8001);   // R4 both negative

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      bit          v, op, as, bs;
      bit [EW-1:0] ae, be;
      bit [FW-1:0] af, bf;
      int          mode;
      v    = ($urandom_range(0, 99) < 85);
      op   = $urandom_range(0, 1);
      as   = $urandom_range(0, 1);
      bs   = $urandom_range(0, 1);
      ae   = EW'($urandom);
      af   = FW'($urandom) | (FW'(1) << (FW - 1));
      bf   = FW'($urandom) | (FW'(1) << (FW - 1));
      mode = $urandom_range(0, 3);
      case (mode)
        0: be = ae;
        1: be = ae + EW'($urandom_range(0, 6)) - EW'(3);
        2: be = EW'($urandom);
        default: begin
          // deep cancellation: same exponent, opposite effective signs
          be = ae;
          bf = af ^ FW'($urandom_range(0, 15));
          bf[FW-1] = 1'b1;
          bs = as ^ op ^ 1'b1;
        end
      endcase
      step(v, op, as, ae, af, bs, be, bf);
    end

    // Drain
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, '0, 0, '0, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule